// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path right after the MAC's byte deserialiser. It looks at each frame's destination address and decides, under a handful of static control inputs, whether the frame goes on to frame storage. Several acceptance modes can be active at the same time, and a frame passes if any one of them accepts it:

- an exact match against the 48-bit station address;
- acceptance of any group-addressed frame;
- a 64-entry hash lookup for group addresses;
- a promiscuous mode that takes every frame.

Accepted frames leave on a valid/ready byte stream with start and end markers. The four trailing CRC bytes can be removed on request.

Incoming bytes wait in a six-byte hold line, so the whole destination address is known before the first byte leaves. The same line holds back the CRC bytes, so they can be dropped at the end of the frame. CRC status and frame length are only known at the last byte, and by then most of the frame has already gone downstream. A frame that fails either test is therefore flagged on its final output beat (`m_discard`) so that storage can drop it. The receive enable and the strip setting are sampled at each frame's first byte. A change in the middle of a frame therefore affects only later frames.

Back-pressure rules:
- An input beat transfers when `s_valid && s_ready`.
- An output beat transfers when `m_valid && m_ready`.
- `s_ready` may depend combinationally on `m_ready`.
- `m_valid` never depends on `m_ready`.
- Once `m_valid` is high it stays high, with `m_data` and the markers unchanged, until the beat is taken, as long as the source keeps `s_valid` and its data steady while `s_ready` is low.
- After the last input byte of an accepted frame, the held bytes drain with `s_ready` low.

Top module: `rx_addr_filter`

## Requirements
- R1: With `acc_all` set and the frame's enable sampled high, every frame of 6 bytes or more is delivered, whatever its destination address.
- R2: With `acc_ucast` set, a frame is delivered when its destination address equals `station_addr`. The first received byte maps to bits [47:40]. A frame whose address differs in any bit is not delivered by this mode.
- R3: With `acc_mcast` set, every frame whose group bit is 1 is delivered, broadcast included. The group bit is bit 0 of the first address byte. A frame whose group bit is 0 is not delivered by this mode.
- R4: With `acc_hash` set, a group-addressed frame is delivered when `hash_table[idx]` is 1. To form `idx`, run a reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, no final inversion) over the six address bytes, first byte first and LSB first within each byte; `idx` is bits [31:26] of the result.
- R5: When no mode accepts a frame, or `rx_en` was low at the frame's first byte, no beat of that frame appears on the output.
- R6: With `strip_crc` sampled high at the first byte, an accepted frame of L bytes yields its first L-4 bytes. With it low, all L bytes are delivered. Bytes are delivered in order and unchanged.
- R7: `rx_en` is sampled at each frame's first byte. Clearing it mid-frame does not shorten the frame in progress, and setting it mid-frame does not admit the frame in progress.
- R8: The last output beat of a delivered frame carries `m_discard`=1 exactly when `s_crc_ok` was low on the input end beat, or the frame had fewer than 14 bytes.
- R9: While `m_valid` is high and `m_ready` is low, `s_ready` is low, and on the next cycle `m_valid` is still high with `m_data` unchanged.
- R10: Every delivered frame starts with a beat carrying `m_sof` and ends with exactly one beat carrying `m_eof`, with no `m_sof` in between. A frame shorter than 6 bytes produces no output.
- R11: During and right after reset, `m_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can take an input byte |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | First byte of frame |
| s_eof | input | 1 | Last byte of frame |
| s_crc_ok | input | 1 | Frame CRC good, read with the end beat |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the output byte |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | First delivered byte of frame |
| m_eof | output | 1 | Last delivered byte of frame |
| m_discard | output | 1 | With m_eof: frame is bad or too short |
| station_addr | input | 48 | Station address, first byte in [47:40] |
| hash_table | input | 64 | Group-address hash table |
| rx_en | input | 1 | Receive enable, sampled per frame |
| acc_all | input | 1 | Accept every frame |
| acc_ucast | input | 1 | Accept exact station-address match |
| acc_mcast | input | 1 | Accept all group-addressed frames |
| acc_hash | input | 1 | Accept group addresses that hit the hash table |
| strip_crc | input | 1 | Remove trailing four CRC bytes |

## Verification
The output-stability properties assume the source follows the valid/ready rule: while `s_ready` is low, it keeps `s_valid`, the byte and the markers steady. The marker properties assume well-formed framing: every frame opens with `s_sof` and closes with `s_eof`, and no bytes arrive between frames. The bench drives each byte and leaves it unchanged until it samples `s_ready` high. It always sends complete frames and changes only `rx_en` between their bytes. It also runs a sink that stalls on a fixed pattern, so the hold and drain paths are exercised under back-pressure.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W     = 48;
  localparam int HASH_BITS = 6;
  localparam int HASH_SIZE = 1 << HASH_BITS;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  function automatic logic [HASH_BITS-1:0] group_hash(input logic [MAC_W-1:0] da);
    logic [31:0] acc;
    logic        fb;
    acc = '1;
    for (int b = 0; b < MAC_W/8; b++) begin
      for (int k = 0; k < 8; k++) begin
        fb  = acc[0] ^ da[MAC_W-1-8*b-7+k];
        acc = acc >> 1;
        if (fb) acc = acc ^ CRC_POLY_R;
      end
    end
    return acc[31 -: HASH_BITS];
  endfunction
endpackage

// File: rtl/rxf_hold_line.sv
module rxf_hold_line #(
  parameter int W     = 8,
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [W-1:0]     din,
  output logic [DEPTH*W-1:0] taps
);
  logic [W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == DEPTH-1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        stage[i] <= '0;
        else if (shift_en) stage[i] <= din;
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        stage[i] <= '0;
        else if (shift_en) stage[i] <= stage[i+1];
    end
    assign taps[i*W +: W] = stage[i];
  end
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0]     da,
  input  logic [MAC_W-1:0]     station_addr,
  input  logic [HASH_SIZE-1:0] hash_table,
  input  logic                 acc_all,
  input  logic                 acc_ucast,
  input  logic                 acc_mcast,
  input  logic                 acc_hash,
  output logic                 hit
);
  logic                 group_bit;
  logic [HASH_BITS-1:0] idx;

  assign group_bit = da[MAC_W-8];
  assign idx       = group_hash(da);

  always_comb begin
    hit = acc_all;
    if (acc_ucast && (da == station_addr))          hit = 1'b1;
    if (acc_mcast && group_bit)                     hit = 1'b1;
    if (acc_hash && group_bit && hash_table[idx])   hit = 1'b1;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int CRC_BYTES = 4,
  parameter int MIN_LEN   = 14,
  parameter int LEN_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [7:0]           s_data,
  input  logic                 s_sof,
  input  logic                 s_eof,
  input  logic                 s_crc_ok,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [7:0]           m_data,
  output logic                 m_sof,
  output logic                 m_eof,
  output logic                 m_discard,
  input  logic [MAC_W-1:0]     station_addr,
  input  logic [HASH_SIZE-1:0] hash_table,
  input  logic                 rx_en,
  input  logic                 acc_all,
  input  logic                 acc_ucast,
  input  logic                 acc_mcast,
  input  logic                 acc_hash,
  input  logic                 strip_crc
);
  localparam int HOLD   = MAC_W / 8;
  localparam int FILL_W = $clog2(HOLD + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HOLD);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(HOLD - 1);
  localparam logic [FILL_W-1:0] DRAIN_STRIP = FILL_W'(HOLD - CRC_BYTES);
  localparam logic [LEN_W-1:0]  LEN_MAX = '1;

  logic              busy, draining, pass, bad_q, sof_pend, en_frame, strip_frame;
  logic [FILL_W-1:0] fill, drain_left;
  logic [LEN_W-1:0]  len, len_next;
  logic [HOLD*8-1:0] taps;
  logic [MAC_W-1:0]  cand_da;
  logic              hit, full, run_out, in_fire, out_fire, shift_en, pass_next;

  rxf_hold_line #(.W(8), .DEPTH(HOLD)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(s_data), .taps(taps)
  );

  always_comb begin
    for (int i = 0; i < HOLD-1; i++)
      cand_da[(HOLD-1-i)*8 +: 8] = taps[(i+1)*8 +: 8];
    cand_da[7:0] = s_data;
  end

  rxf_match u_match (
    .da(cand_da), .station_addr(station_addr), .hash_table(hash_table),
    .acc_all(acc_all), .acc_ucast(acc_ucast), .acc_mcast(acc_mcast),
    .acc_hash(acc_hash), .hit(hit)
  );

  assign full      = (fill == FILL_FULL);
  assign run_out   = !draining && busy && !s_sof && s_valid && full && pass;
  assign s_ready   = !draining && (!run_out || m_ready);
  assign m_valid   = draining || run_out;
  assign m_data    = taps[7:0];
  assign m_sof     = m_valid && sof_pend;
  assign m_eof     = draining && (drain_left == FILL_W'(1));
  assign m_discard = m_eof && bad_q;
  assign in_fire   = s_valid && s_ready;
  assign out_fire  = m_valid && m_ready;
  assign shift_en  = in_fire || (draining && out_fire);

  assign len_next  = s_sof ? LEN_W'(1) : ((len == LEN_MAX) ? len : len + LEN_W'(1));
  assign pass_next = s_sof ? 1'b0
                   : (busy && fill == FILL_LAST) ? (hit && en_frame) : pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; draining <= 1'b0; pass <= 1'b0; bad_q <= 1'b0;
      sof_pend <= 1'b0; en_frame <= 1'b0; strip_frame <= 1'b0;
      fill <= '0; drain_left <= '0; len <= '0;
    end else if (draining) begin
      if (out_fire) begin
        sof_pend   <= 1'b0;
        drain_left <= drain_left - FILL_W'(1);
        if (drain_left == FILL_W'(1)) begin
          draining <= 1'b0;
          fill     <= '0;
        end
      end
    end else if (in_fire && (busy || s_sof)) begin
      len  <= len_next;
      pass <= pass_next;
      if (s_sof) begin
        fill        <= FILL_W'(1);
        en_frame    <= rx_en;
        strip_frame <= strip_crc;
        sof_pend    <= 1'b1;
      end else if (!full) begin
        fill <= fill + FILL_W'(1);
      end
      if (run_out) sof_pend <= 1'b0;
      if (s_eof) begin
        busy  <= 1'b0;
        bad_q <= !s_crc_ok || (len_next < LEN_W'(MIN_LEN));
        if (pass_next) begin
          draining   <= 1'b1;
          drain_left <= (s_sof ? strip_crc : strip_frame) ? DRAIN_STRIP : FILL_FULL;
        end else begin
          fill <= '0;
        end
      end else begin
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_sof,
  input logic       m_eof,
  input logic       m_discard
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) open_q <= 1'b0;
    else if (m_valid && m_ready) begin
      if (m_eof)      open_q <= 1'b0;
      else if (m_sof) open_q <= 1'b1;
    end

  // R11: output idle while in reset
  always_comb if (!rst_n) assert_reset_idle_R11: assert (!m_valid);

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_eof));
  assert_discard_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_discard |-> m_valid && m_eof);
  assert_frame_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !open_q |-> m_sof);
  assert_no_inner_sof_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && open_q |-> !m_sof);
endmodule

bind rx_addr_filter rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof),
  .m_discard(m_discard)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 0, s_sof = 0, s_eof = 0, s_crc_ok = 0, m_ready = 1;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_sof, m_eof, m_discard;
  logic [7:0] m_data;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic [63:0] hash_table = '0;
  logic rx_en = 0, acc_all = 0, acc_ucast = 0, acc_mcast = 0, acc_hash = 0, strip_crc = 0;

  int total = 0, bad = 0, cyc = 0, bp_err = 0;
  bit stall_on = 0, done = 0;
  logic [7:0] fb [64];
  logic [7:0] q_data [$];
  bit q_sof [$], q_eof [$], q_disc [$];

  always #2 clk = ~clk;

  rx_addr_filter u_dut (.*);

  always @(posedge clk) begin
    cyc++;
    #1 m_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (m_valid && m_ready) begin
      q_data.push_back(m_data); q_sof.push_back(m_sof);
      q_eof.push_back(m_eof); q_disc.push_back(m_discard);
    end
    if (m_valid && !m_ready && s_ready) bp_err++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] da);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int j = 0; j < 6; j++) begin
      r = r ^ {24'h0, da[47-8*j -: 8]};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r[31:26];
  endfunction

  task automatic build(input logic [47:0] da, input int len, input int seed);
    for (int i = 0; i < 64; i++)
      fb[i] = (i < 6) ? da[47-8*i -: 8] : 8'((i * 13 + seed) & 255);
  endtask

  task automatic send(input int len, input bit crc_ok, input int flip_at, input bit flip_val);
    bit ok;
    for (int i = 0; i < len; i++) begin
      if (i == flip_at) rx_en = flip_val;
      s_valid = 1; s_data = fb[i]; s_sof = (i == 0); s_eof = (i == len-1); s_crc_ok = crc_ok;
      do begin
        @(negedge clk); ok = s_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    s_valid = 0; s_sof = 0; s_eof = 0;
    repeat (30) @(posedge clk);
    #1;
  endtask

  task automatic expect_frame(input string req, input int len, input bit pass,
                              input bit strip, input bit disc);
    int exp_n = !pass ? 0 : (strip ? len - 4 : len);
    int n = q_data.size();
    int bad_at = -1;
    check(n == exp_n, {req, " beat count"}, n, exp_n);
    if (exp_n > 0 && n == exp_n) begin
      for (int i = 0; i < n; i++) if (q_data[i] != fb[i] && bad_at < 0) bad_at = i;
      check(bad_at < 0, {req, " data order"}, bad_at < 0 ? 0 : q_data[bad_at], bad_at < 0 ? 0 : fb[bad_at]);
      check(q_sof[0] && q_eof[n-1], {req, " R10 markers"}, int'(q_sof[0]) + int'(q_eof[n-1]), 2);
      check(q_disc[n-1] == disc, {req, " R8 discard"}, q_disc[n-1], disc);
    end
    q_data.delete(); q_sof.delete(); q_eof.delete(); q_disc.delete();
  endtask

  task automatic modes(input bit a, input bit u, input bit m, input bit h, input bit s);
    acc_all = a; acc_ucast = u; acc_mcast = m; acc_hash = h; strip_crc = s; rx_en = 1;
  endtask

  task automatic t_reset();
    check(m_valid == 0, "R11 idle in reset", m_valid, 0);
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(m_valid == 0, "R11 idle after reset", m_valid, 0);
  endtask

  task automatic t_all();
    modes(1, 0, 0, 0, 0); build(48'h0A_BB_CC_DD_EE_01, 20, 3); send(20, 1, -1, 0);
    expect_frame("R1 R6 all no-strip", 20, 1, 0, 0);
  endtask

  task automatic t_ucast();
    modes(0, 1, 0, 0, 1); build(station_addr, 22, 5); send(22, 1, -1, 0);
    expect_frame("R2 R6 ucast strip", 22, 1, 1, 0);
    build(station_addr ^ 48'h00_00_00_00_00_80, 22, 5); send(22, 1, -1, 0);
    expect_frame("R2 ucast mismatch", 22, 0, 1, 0);
  endtask

  task automatic t_mcast();
    modes(0, 0, 1, 0, 0); build(48'hFF_FF_FF_FF_FF_FF, 16, 9); send(16, 1, -1, 0);
    expect_frame("R3 broadcast", 16, 1, 0, 0);
    build(48'h01_00_5E_10_20_30, 18, 2); send(18, 1, -1, 0);
    expect_frame("R3 group addr", 18, 1, 0, 0);
    build(station_addr, 18, 2); send(18, 1, -1, 0);
    expect_frame("R3 unicast rejected", 18, 0, 0, 0);
  endtask

  task automatic t_hash();
    logic [47:0] da = 48'h33_33_00_00_00_FB;
    logic [5:0] idx = ref_hash(da);
    modes(0, 0, 0, 1, 1);
    hash_table = 64'h1 << idx; build(da, 24, 4); send(24, 1, -1, 0);
    expect_frame("R4 hash hit", 24, 1, 1, 0);
    hash_table = ~(64'h1 << idx); send(24, 1, -1, 0);
    expect_frame("R4 hash miss", 24, 0, 1, 0);
    hash_table = '1; build(48'h04_00_00_00_00_01, 24, 4); send(24, 1, -1, 0);
    expect_frame("R4 unicast ignored by hash", 24, 0, 1, 0);
    hash_table = '0;
  endtask

  task automatic t_none();
    modes(0, 0, 0, 0, 0); build(48'hFF_FF_FF_FF_FF_FF, 20, 1); send(20, 1, -1, 0);
    expect_frame("R5 no mode", 20, 0, 0, 0);
    modes(1, 0, 0, 0, 0); rx_en = 0; send(20, 1, -1, 0);
    expect_frame("R5 disabled", 20, 0, 0, 0);
  endtask

  task automatic t_bad();
    modes(1, 0, 0, 0, 0); build(48'h01_02_03_04_05_06, 20, 6); send(20, 0, -1, 0);
    expect_frame("R8 bad crc", 20, 1, 0, 1);
    strip_crc = 1; send(10, 1, -1, 0);
    expect_frame("R8 runt", 10, 1, 1, 1);
    strip_crc = 0; send(14, 1, -1, 0);
    expect_frame("R8 minimum length ok", 14, 1, 0, 0);
    send(4, 1, -1, 0);
    expect_frame("R10 tiny frame", 4, 0, 0, 0);
  endtask

  task automatic t_enable();
    modes(1, 0, 0, 0, 0); build(48'h0C_00_00_00_00_01, 24, 8); send(24, 1, 8, 0);
    expect_frame("R7 clear mid-frame", 24, 1, 0, 0);
    rx_en = 0; send(24, 1, 8, 1);
    expect_frame("R7 set mid-frame", 24, 0, 0, 0);
    send(24, 1, -1, 0);
    expect_frame("R7 next frame enabled", 24, 1, 0, 0);
  endtask

  task automatic t_backpressure();
    modes(0, 1, 0, 0, 1); stall_on = 1; bp_err = 0;
    build(station_addr, 30, 11); send(30, 1, -1, 0);
    stall_on = 0; repeat (2) @(posedge clk); #1;
    expect_frame("R9 stalled sink", 30, 1, 1, 0);
    check(bp_err == 0, "R9 s_ready low while stalled", bp_err, 0);
  endtask

  initial begin
    t_reset();
    t_all();
    t_ucast();
    t_mcast();
    t_hash();
    t_none();
    t_bad();
    t_enable();
    t_backpressure();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule